// File: doc/BRIEF.md
# Gated Root Counter Channel

One timer channel of a peripheral I/O processor. It holds a count, a control/status word and a compare value, all reached over a simple write port and a combinational read port. Each clock the channel may advance its count by one. Whether it advances depends on three things: the selected clock source (every cycle, or an external strobe), a prescaler, and an optional gate input that is usually driven by a video blanking strobe. The parameter `CNT_W` builds the channel as a 16-bit or a 32-bit counter. The overflow point and the prescaler encoding both depend on that width.

When the count steps onto the compare value, or reaches its overflow point, the channel records the event in status bits. If the matching enable is set, it also sends a one-cycle request pulse to an external interrupt status register. That register's bit for this channel is fed back on `irq_pending_in`, and the channel drops its status bits once the bit reads as clear.

Top module: `root_counter`

## Requirements
- R1: After reset and after any control write, the count is 0, the status reads interrupt flag (bit 10) = 1 and reached flags (bits 11, 12) = 0, and the one-shot target interrupt is re-armed. A control read returns the written bits 9:0 and 14:13 together with the live bits 10 to 12, and the read has no side effect.
- R2: Each enabled tick adds one to the count. A count write (address 0) loads the value masked to `CNT_W` bits and restarts the prescaler phase. A target write (address 2) is used from the next compare.
- R3: When the next count would reach 0xFFFF (16-bit) or 0xFFFEE000 (32-bit), the count returns to 0 instead. Bit 12 is set and the target interrupt is re-armed. If bit 5 is set, a request is raised.
- R4: When a tick steps the count onto the target value, bit 11 is set. With bit 3 set the count becomes 0; with bit 3 clear it holds the target value and keeps counting.
- R5: With bit 4 set, a target match raises a request. With bit 6 clear only the first match does so, until an overflow or a control write re-arms the channel. With bit 6 set every match does so.
- R6: With bit 7 set, each raised request also drives bit 10 low. With bit 7 clear, bit 10 stays 1.
- R7: 32-bit channels divide the ticks by 1, 8, 16 or 256 for control bits 14:13 = 0, 1, 2, 3. 16-bit channels divide by 8 when bit 9 is set and by 1 otherwise.
- R8: With bit 8 set, the tick source is the `alt_tick` strobe; with bit 8 clear it is every clock.
- R9: Gate enabled (bit 0) with gate mode (bits 2:1) 0: the counter advances only while `gate_in` is high.
- R10: Gate mode 1: the counter runs freely, and each rising edge of `gate_in` clears it to 0.
- R11: Gate mode 2: the counter is halted after the control write. A rising edge of `gate_in` clears it and starts it, and it advances while the gate stays high. A falling edge stops it.
- R12: Gate mode 3: the counter is halted after the control write until the first rising edge of `gate_in`, and it then runs freely.
- R13: In a cycle where `irq_pending_in` is low and no request pulse is in flight, bits 11 and 12 clear and bit 10 returns to 1. A new event in the same cycle takes priority.
- R14: `irq_o` is a registered pulse that is high for exactly one cycle per raised request. It appears in the cycle after the clock edge that applied the event to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Write address: 0 count, 1 control, 2 target |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 2 | Read address (same map, 3 reads 0) |
| bus_rdata | output | 32 | Combinational read data |
| alt_tick | input | 1 | Alternate tick strobe |
| gate_in | input | 1 | Gate level (blanking strobe) |
| irq_pending_in | input | 1 | This channel's bit in the external status register |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
Every count, flag and compare result becomes visible one clock edge after the tick or write that caused it. The request pulse is visible after that same edge and clears after the next one. A status clear through R13 therefore lands two edges after the causing event at the earliest. The bench updates a behavioural model on the rising edge from the same inputs and compares outputs on the falling edge. It rotates the read address over count, control and target so that all three are compared. Directed checks wait for the matching read address, and they are taken only while the counter is halted or its read value is stable.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam logic [1:0] RA_COUNT  = 2'd0;
  localparam logic [1:0] RA_MODE   = 2'd1;
  localparam logic [1:0] RA_TARGET = 2'd2;

  typedef enum logic [1:0] {
    GM_LEVEL   = 2'd0,
    GM_RESTART = 2'd1,
    GM_WINDOW  = 2'd2,
    GM_ONCE    = 2'd3
  } gate_mode_e;

  // Value the incremented count must not reach; reaching it wraps to zero.
  function automatic logic [32:0] ovf_limit(int w);
    if (w >= 32) return 33'h0_FFFE_E000;
    return 33'h0_0000_FFFF;
  endfunction

  // Last prescaler phase (divide ratio minus one) for a given width and selection.
  function automatic logic [7:0] div_last(int w, logic [1:0] wide_sel, logic narrow_sel);
    if (w >= 32) begin
      case (wide_sel)
        2'd0: return 8'd0;
        2'd1: return 8'd7;
        2'd2: return 8'd15;
        default: return 8'd255;
      endcase
    end
    return narrow_sel ? 8'd7 : 8'd0;
  endfunction
endpackage

// File: rtl/rc_prescale.sv
module rc_prescale (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       use_alt,
  input  logic       alt_tick,
  input  logic [7:0] last,
  output logic       tick
);
  logic [7:0] phase_q;
  logic       src;

  assign src  = use_alt ? alt_tick : 1'b1;
  assign tick = src && (phase_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (clr)     phase_q <= '0;
    else if (src)     phase_q <= (phase_q == last) ? 8'd0 : phase_q + 8'd1;
  end
endmodule

// File: rtl/rc_gate.sv
module rc_gate
  import rc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic       wr_gen,
  input  logic       wr_gm_hi,
  input  logic       gate_en,
  input  gate_mode_e gm,
  input  logic       gate_in,
  output logic       step_ok,
  output logic       gate_clr
);
  logic prev_q, run_q, g_start, g_end;

  assign g_start = gate_in & ~prev_q;
  assign g_end   = ~gate_in & prev_q;

  always_comb begin
    if (!gate_en) step_ok = 1'b1;
    else begin
      case (gm)
        GM_LEVEL:   step_ok = gate_in;
        GM_RESTART: step_ok = 1'b1;
        GM_WINDOW:  step_ok = run_q & gate_in;
        default:    step_ok = run_q;
      endcase
    end
  end

  assign gate_clr = gate_en & g_start & ((gm == GM_RESTART) | (gm == GM_WINDOW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= 1'b1;
    end else begin
      prev_q <= gate_in;
      if (mode_wr)                               run_q <= ~(wr_gen & wr_gm_hi);
      else if (gate_en && g_start && gm[1])      run_q <= 1'b1;
      else if (gate_en && g_end && gm == GM_WINDOW) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rc_core.sv
module rc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] target,
  input  logic             rst_on_tgt,
  input  logic             ie_tgt,
  input  logic             ie_ovf,
  input  logic             rep,
  input  logic             tog,
  input  logic             gate_clr,
  input  logic             step_ok,
  input  logic             tick,
  input  logic             pend_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_n,
  output logic             flag_t,
  output logic             flag_o,
  output logic             irq_o,
  output logic             tgt_evt,
  output logic             ovf_evt
);
  localparam logic [32:0]    LIM_ALL = rc_pkg::ovf_limit(CNT_W);
  localparam logic [CNT_W:0] LIM     = LIM_ALL[CNT_W:0];
  localparam logic [CNT_W:0] ONE     = {{CNT_W{1'b0}}, 1'b1};

  logic             armed;
  logic [CNT_W:0]   nxt;
  logic             step_act, tgt_irq, ovf_irq, stat_clr;

  assign nxt      = {1'b0, cnt_o} + ONE;
  assign step_act = tick & step_ok & ~mode_wr & ~count_wr & ~gate_clr;
  assign ovf_evt  = step_act & (nxt >= LIM);
  assign tgt_evt  = step_act & ~ovf_evt & (nxt[CNT_W-1:0] == target);
  assign tgt_irq  = tgt_evt & ie_tgt & armed;
  assign ovf_irq  = ovf_evt & ie_ovf;
  assign stat_clr = ~pend_in & ~irq_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      flag_n <= 1'b1;
      flag_t <= 1'b0;
      flag_o <= 1'b0;
      armed  <= 1'b1;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= tgt_irq | ovf_irq;
      if (mode_wr) begin
        cnt_o  <= '0;
        flag_n <= 1'b1;
        flag_t <= 1'b0;
        flag_o <= 1'b0;
        armed  <= 1'b1;
      end else begin
        if (stat_clr) begin
          flag_n <= 1'b1;
          flag_t <= 1'b0;
          flag_o <= 1'b0;
        end
        if (count_wr)      cnt_o <= wdata;
        else if (gate_clr) cnt_o <= '0;
        else if (ovf_evt) begin
          cnt_o  <= '0;
          flag_o <= 1'b1;
          armed  <= 1'b1;
          if (ovf_irq && tog) flag_n <= 1'b0;
        end else if (tgt_evt) begin
          flag_t <= 1'b1;
          cnt_o  <= rst_on_tgt ? '0 : nxt[CNT_W-1:0];
          if (tgt_irq && !rep) armed  <= 1'b0;
          if (tgt_irq && tog)  flag_n <= 1'b0;
        end else if (step_act) cnt_o <= nxt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/root_counter.sv
module root_counter
  import rc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  input  logic        alt_tick,
  input  logic        gate_in,
  input  logic        irq_pending_in,
  output logic        irq_o
);
  localparam logic [9:0] LO_WMASK = 10'h3FF;

  logic             mode_wr, count_wr, tgt_wr;
  logic [9:0]       mode_lo;
  logic [1:0]       mode_hi;
  logic [CNT_W-1:0] tgt_q, cnt_q;
  logic [7:0]       div_l;
  logic             tick, step_ok, gate_clr;
  logic             flag_n, flag_t, flag_o, tgt_evt, ovf_evt;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:15];
  assign mode_wr  = bus_wr && (bus_addr == RA_MODE);
  assign count_wr = bus_wr && (bus_addr == RA_COUNT);
  assign tgt_wr   = bus_wr && (bus_addr == RA_TARGET);
  assign div_l    = div_last(CNT_W, mode_hi, mode_lo[9]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_lo <= '0;
      mode_hi <= '0;
      tgt_q   <= '0;
    end else begin
      if (mode_wr) begin
        mode_lo <= bus_wdata[9:0] & LO_WMASK;
        mode_hi <= bus_wdata[14:13];
      end
      if (tgt_wr) tgt_q <= bus_wdata[CNT_W-1:0];
    end
  end

  rc_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr | count_wr),
    .use_alt(mode_lo[8]), .alt_tick(alt_tick), .last(div_l), .tick(tick)
  );

  rc_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr),
    .wr_gen(bus_wdata[0]), .wr_gm_hi(bus_wdata[2]),
    .gate_en(mode_lo[0]), .gm(gate_mode_e'(mode_lo[2:1])), .gate_in(gate_in),
    .step_ok(step_ok), .gate_clr(gate_clr)
  );

  rc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .count_wr(count_wr),
    .wdata(bus_wdata[CNT_W-1:0]), .target(tgt_q),
    .rst_on_tgt(mode_lo[3]), .ie_tgt(mode_lo[4]), .ie_ovf(mode_lo[5]),
    .rep(mode_lo[6]), .tog(mode_lo[7]),
    .gate_clr(gate_clr), .step_ok(step_ok), .tick(tick), .pend_in(irq_pending_in),
    .cnt_o(cnt_q), .flag_n(flag_n), .flag_t(flag_t), .flag_o(flag_o),
    .irq_o(irq_o), .tgt_evt(tgt_evt), .ovf_evt(ovf_evt)
  );

  always_comb begin
    case (bus_raddr)
      RA_COUNT:  bus_rdata = 32'(cnt_q);
      RA_MODE:   bus_rdata = 32'({mode_hi, flag_o, flag_t, flag_n, mode_lo});
      RA_TARGET: bus_rdata = 32'(tgt_q);
      default:   bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic             tgt_evt,
  input logic             ovf_evt,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic             flag_n,
  input logic             flag_t,
  input logic             flag_o
);
  a_r1_ctl_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (cnt == '0) && flag_n && !flag_t && !flag_o);

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0) && flag_o);

  a_r4_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_evt |=> flag_t);

  a_r6_flag_drop_with_request: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_n) |-> irq_o);

  a_r14_request_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tgt_evt || ovf_evt));
endmodule

bind root_counter rc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .tgt_evt(tgt_evt),
  .ovf_evt(ovf_evt), .irq_o(irq_o), .cnt(cnt_q),
  .flag_n(flag_n), .flag_t(flag_t), .flag_o(flag_o)
);

// File: tb/sim_root_counter.sv
module sim_root_counter;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bwr = 1'b0, alt = 1'b0, gate = 1'b0, pend = 1'b1;
  logic [1:0]  baddr = 2'd0, raddr = 2'd0;
  logic [31:0] bwd = 32'd0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;

  int    total = 0, bad = 0, p0 = 0, p1 = 0;
  string phase = "R1 reset";
  bit    done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  root_counter #(.CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_addr(baddr), .bus_wdata(bwd),
    .bus_raddr(raddr), .bus_rdata(rd0), .alt_tick(alt), .gate_in(gate),
    .irq_pending_in(pend), .irq_o(irq0));

  root_counter #(.CNT_W(32)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_addr(baddr), .bus_wdata(bwd),
    .bus_raddr(raddr), .bus_rdata(rd1), .alt_tick(alt), .gate_in(gate),
    .irq_pending_in(pend), .irq_o(irq1));

  // ---------------- behavioural reference ----------------
  longint      m_cnt[2], m_tgt[2];
  int unsigned m_ctl[2];
  int          m_pc[2];
  bit          m_fn[2], m_ft[2], m_fo[2], m_arm[2], m_irq[2], m_run[2], m_gp[2];

  function automatic longint wmask(int k);
    return (k == 1) ? 64'hFFFF_FFFF : 64'hFFFF;
  endfunction

  function automatic int ratio(int k);
    if (k == 1) begin
      case ((m_ctl[k] >> 13) & 3)
        0: return 1;
        1: return 8;
        2: return 16;
        default: return 256;
      endcase
    end
    return (((m_ctl[k] >> 9) & 1) != 0) ? 8 : 1;
  endfunction

  function automatic longint model_read(int k, int a);
    case (a)
      0: return m_cnt[k];
      1: return longint'(m_ctl[k]) | (longint'(m_fn[k]) << 10) |
                (longint'(m_ft[k]) << 11) | (longint'(m_fo[k]) << 12);
      2: return m_tgt[k];
      default: return 0;
    endcase
  endfunction

  function automatic bit cbit(int k, int b);
    return ((m_ctl[k] >> b) & 1) != 0;
  endfunction

  task automatic model_edge(int k);
    bit mw, cw, tw, gen, gs, ge, src, tick, ok, gclr, req;
    int gm, dv;
    longint lim, n;
    mw  = bwr && baddr == 2'd1;
    cw  = bwr && baddr == 2'd0;
    tw  = bwr && baddr == 2'd2;
    gen = cbit(k, 0);
    gm  = (m_ctl[k] >> 1) & 3;
    gs  = gate && !m_gp[k];
    ge  = !gate && m_gp[k];
    dv  = ratio(k);
    src = cbit(k, 8) ? alt : 1'b1;
    tick = src && (m_pc[k] == dv - 1);
    if (!gen) ok = 1;
    else if (gm == 0) ok = gate;
    else if (gm == 1) ok = 1;
    else if (gm == 2) ok = m_run[k] && gate;
    else ok = m_run[k];
    gclr = gen && gs && (gm == 1 || gm == 2);
    lim  = (k == 1) ? 64'hFFFE_E000 : 64'hFFFF;
    req  = 0;
    if (mw || cw) m_pc[k] = 0;
    else if (src) m_pc[k] = (m_pc[k] == dv - 1) ? 0 : m_pc[k] + 1;
    if (mw) m_run[k] = !(bwd[0] && bwd[2]);
    else if (gen && gs && gm >= 2) m_run[k] = 1;
    else if (gen && ge && gm == 2) m_run[k] = 0;
    if (mw) begin
      m_ctl[k] = bwd & 32'h63FF;
      m_cnt[k] = 0; m_fn[k] = 1; m_ft[k] = 0; m_fo[k] = 0; m_arm[k] = 1;
    end else begin
      if (!pend && !m_irq[k]) begin m_fn[k] = 1; m_ft[k] = 0; m_fo[k] = 0; end
      if (cw) m_cnt[k] = longint'(bwd) & wmask(k);
      else if (gclr) m_cnt[k] = 0;
      else if (tick && ok) begin
        n = m_cnt[k] + 1;
        if (n >= lim) begin
          m_cnt[k] = 0; m_fo[k] = 1; m_arm[k] = 1;
          if (cbit(k, 5)) begin req = 1; if (cbit(k, 7)) m_fn[k] = 0; end
        end else if (n == m_tgt[k]) begin
          m_ft[k] = 1;
          m_cnt[k] = cbit(k, 3) ? 0 : n;
          if (cbit(k, 4) && m_arm[k]) begin
            req = 1;
            if (!cbit(k, 6)) m_arm[k] = 0;
            if (cbit(k, 7)) m_fn[k] = 0;
          end
        end else m_cnt[k] = n;
      end
      if (tw) m_tgt[k] = longint'(bwd) & wmask(k);
    end
    m_irq[k] = req;
    m_gp[k]  = gate;
  endtask

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_cnt[k] = 0; m_tgt[k] = 0; m_ctl[k] = 0; m_pc[k] = 0;
        m_fn[k] = 1; m_ft[k] = 0; m_fo[k] = 0; m_arm[k] = 1;
        m_irq[k] = 0; m_run[k] = 1; m_gp[k] = 0;
      end else model_edge(k);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({phase, " u0 read"}, longint'(rd0), model_read(0, int'(raddr)));
      chk({phase, " u1 read"}, longint'(rd1), model_read(1, int'(raddr)));
      chk({phase, " u0 irq"},  longint'(irq0), longint'(m_irq[0]));
      chk({phase, " u1 irq"},  longint'(irq1), longint'(m_irq[1]));
      if (irq0) p0++;
      if (irq1) p1++;
      raddr = (raddr == 2'd2) ? 2'd0 : raddr + 2'd1;
    end
  end

  task automatic check_rd(int k, int a, longint exp, string tag);
    forever begin
      @(negedge clk); #1;
      if (int'(raddr) == a) break;
    end
    chk(tag, longint'((k == 1) ? rd1 : rd0), exp);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bwr = 1'b1; baddr = a; bwd = d;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_alt();
    @(negedge clk); alt = 1'b1;
    @(negedge clk); alt = 1'b0;
  endtask

  task automatic gate_hold(int n);
    @(negedge clk); gate = 1'b1;
    repeat (n) @(negedge clk);
    gate = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 reset irq u0", longint'(irq0), 0);
    check_rd(0, 1, 64'h400, "R1 reset control u0");
    check_rd(1, 1, 64'h400, "R1 reset control u1");

    // R2 count write masked, free run
    phase = "R2 count";
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0001_1230);
    idle(10);
    wr(2'd1, 32'h100);
    check_rd(0, 0, 0, "R2 frozen after control write u0");

    // R5 one-shot target interrupt, R4 reset on target
    phase = "R5 one-shot";
    wr(2'd2, 32'd20);
    wr(2'd1, 32'h18);
    p0 = 0; p1 = 0;
    idle(70);
    chk("R5 one-shot pulses u0", p0, 1);
    chk("R5 one-shot pulses u1", p1, 1);
    phase = "R5 repeat";
    wr(2'd1, 32'h58);
    p0 = 0; p1 = 0;
    idle(70);
    chk("R5 repeat pulses u0", p0, 3);
    chk("R5 repeat pulses u1", p1, 3);

    // R6 flag drops with the request
    phase = "R6 toggle";
    wr(2'd1, 32'h98);
    idle(25);
    check_rd(0, 1, 64'h898, "R6 control after match u0");
    check_rd(1, 1, 64'h898, "R6 control after match u1");

    // R3 overflow per width
    phase = "R3 overflow";
    wr(2'd1, 32'h20);
    wr(2'd0, 32'h0000_FFF0);
    p0 = 0; p1 = 0;
    idle(20);
    chk("R3 16-bit wraps u0", p0, 1);
    chk("R3 32-bit continues u1", p1, 0);
    wr(2'd0, 32'hFFFE_DFF0);
    p0 = 0; p1 = 0;
    idle(20);
    chk("R3 no wrap u0", p0, 0);
    chk("R3 32-bit wraps u1", p1, 1);

    // R7 prescaler encodings, R8 alternate source
    phase = "R7 prescale";
    wr(2'd1, 32'h300);
    repeat (16) pulse_alt();
    check_rd(0, 0, 2, "R7 divide by 8 u0");
    check_rd(1, 0, 16, "R7 bit9 ignored u1");
    wr(2'd1, 32'h2000);
    idle(100);
    wr(2'd1, 32'h6000);
    idle(600);
    phase = "R8 alt source";
    wr(2'd1, 32'h100);
    repeat (5) pulse_alt();
    idle(4);
    check_rd(0, 0, 5, "R8 alt count u0");
    check_rd(1, 0, 5, "R8 alt count u1");

    // R9 gate level
    phase = "R9 gate level";
    wr(2'd1, 32'h01);
    idle(5);
    gate_hold(10);
    idle(5);
    check_rd(0, 0, 10, "R9 counted while high u0");
    check_rd(1, 0, 10, "R9 counted while high u1");

    // R12 wait for first start
    phase = "R12 gate once";
    wr(2'd1, 32'h07);
    idle(5);
    check_rd(0, 0, 0, "R12 halted before start u0");
    gate_hold(2);
    idle(10);

    // R10 restart at start
    phase = "R10 gate restart";
    wr(2'd1, 32'h03);
    idle(30);
    gate_hold(3);
    idle(8);

    // R11 window
    phase = "R11 gate window";
    wr(2'd1, 32'h05);
    idle(6);
    gate_hold(12);
    idle(5);
    check_rd(0, 0, 11, "R11 window count u0");
    check_rd(1, 0, 11, "R11 window count u1");

    // R14 pulse width, R4 flag, R13 status clear
    phase = "R14 pulse";
    wr(2'd2, 32'd5);
    wr(2'd1, 32'h118);
    repeat (4) pulse_alt();
    chk("R14 no early pulse u0", longint'(irq0), 0);
    pulse_alt();
    chk("R14 pulse high u0", longint'(irq0), 1);
    chk("R14 pulse high u1", longint'(irq1), 1);
    idle(1);
    chk("R14 pulse ends u0", longint'(irq0), 0);
    check_rd(0, 1, 64'hD18, "R4 target flag set u0");
    check_rd(1, 0, 0, "R4 count reset on target u1");
    phase = "R13 clear";
    pend = 1'b0;
    idle(3);
    check_rd(0, 1, 64'h518, "R13 flags cleared u0");
    check_rd(1, 1, 64'h518, "R13 flags cleared u1");
    pend = 1'b1;
    idle(4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule